// File: doc/BRIEF.md
# Asynchronous HDLC Framer and Deframer

This block sits between a host byte interface and a byte-wide asynchronous serial line and performs HDLC framing in both directions at once. On the transmit path the host hands over a frame it has already built, one byte per handshake, with the last byte marked. The block wraps the frame in flag bytes, escapes any reserved byte, and appends a 16-bit frame check sequence (FCS). On the receive path the block searches for flags and strips escapes. It filters on the first byte (the address), checks the FCS, and hands the frame to the host followed by one status beat.

The transmit controller has seven states. TX_IDLE moves to TX_OPEN when the host raises valid. TX_OPEN sends the opening flag and moves to TX_DATA. TX_DATA passes payload bytes and moves to TX_FCS_LO after the last one. TX_FCS_LO moves to TX_FCS_HI, which moves to TX_CLOSE. TX_CLOSE sends the closing flag and returns to TX_IDLE. Any byte that needs an escape detours through TX_ESC2, which sends the modified byte and then resumes at the state that would have followed.

The receive controller has five states. RX_HUNT discards bytes until the first flag and then moves to RX_RECV. RX_RECV decodes bytes and acts on each closing flag. A frame to be reported moves to RX_FCS_A when the FCS bytes are to be delivered, and to RX_STAT otherwise. RX_FCS_A moves to RX_FCS_B, RX_FCS_B moves to RX_STAT, and RX_STAT emits the status beat and returns to RX_RECV. The closing flag of one frame also opens the next. All handshakes are valid/ready, and the two paths share nothing but clock and reset.

Top module: `hdlc_async_codec`

## Requirements
- R1: After reset the line output and the host receive output are idle, the transmit input is not ready, and the line receive input is ready. A transmitted frame is a flag 0x7E, then the encoded body, then a closing flag 0x7E.
- R2: On transmit, any body byte equal to 0x7E or 0x7D is sent as 0x7D followed by that byte XOR 0x20. This includes the FCS bytes. The byte that follows a 0x7D on the line is never 0x7E or 0x7D.
- R3: The transmit FCS is the reflected CRC-16 with polynomial 0x1021, preset to 0xFFFF and run over the payload. The result is complemented and sent low byte first.
- R4: The receiver discards every byte before the first flag. Consecutive flags (empty frames) produce no output beat.
- R5: A frame is delivered only if its first decoded byte equals cfg_addr or the broadcast value 0xFF. A frame that fails this check produces no beat at all.
- R6: Each reported frame ends with one beat that has rx_eof=1 and data 0x00. Its rx_fcs_ok is 1 only when the CRC register, run over every decoded byte including the received FCS, equals 0xF0B8.
- R7: With cfg_pass_fcs=1 the two received FCS bytes are delivered as data before the status beat. With cfg_pass_fcs=0 they are withheld.
- R8: A frame that has 1 or 2 decoded bytes, or one where 0x7D is followed directly by a flag, ends with a status beat that has rx_abort=1 and rx_fcs_ok=0.
- R9: A stalled output holds its valid and data until accepted, and stalls on either output leave the byte streams unchanged.
- R10: Transmit and receive run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Host transmit byte |
| tx_valid | input | 1 | Host transmit byte valid |
| tx_last | input | 1 | Marks the final byte of the frame |
| tx_ready | output | 1 | Block accepts the host transmit byte |
| line_tx_data | output | 8 | Encoded byte to the serialiser |
| line_tx_valid | output | 1 | Encoded byte valid |
| line_tx_ready | input | 1 | Serialiser accepts the byte |
| line_rx_data | input | 8 | Received line byte |
| line_rx_valid | input | 1 | Received line byte valid |
| line_rx_ready | output | 1 | Block accepts the line byte |
| cfg_addr | input | 8 | Station address to match |
| cfg_pass_fcs | input | 1 | Deliver received FCS bytes to the host |
| rx_data | output | 8 | Decoded byte to the host |
| rx_valid | output | 1 | Decoded byte or status valid |
| rx_eof | output | 1 | Beat is the end-of-frame status |
| rx_fcs_ok | output | 1 | Status: FCS residue correct |
| rx_abort | output | 1 | Status: runt or aborted frame |
| rx_ready | input | 1 | Host accepts the beat |

## Verification
The bench builds the block with its default parameters: a broadcast address of 0xFF and a minimum decoded length of three bytes. The three-byte minimum puts the runt boundary at one address byte plus two FCS bytes, so frames of one and two decoded bytes reach the abort path. A frame of exactly three bytes (an address-only frame) reaches the shortest delivered frame. The broadcast value of 0xFF lets a single configured address show both the drop case and the always-accept case.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t FLAG_B = 8'h7E;
    localparam byte_t ESC_B  = 8'h7D;
    localparam byte_t FLIP_B = 8'h20;

    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

    // one byte of the reflected CRC-16, LSB first
    function automatic logic [15:0] crc_step(input logic [15:0] c, input byte_t b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < BYTE_W; k++)
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        return r;
    endfunction

    function automatic logic needs_esc(input byte_t b);
        return (b == FLAG_B) || (b == ESC_B);
    endfunction

    typedef enum logic [2:0] {
        TX_IDLE, TX_OPEN, TX_DATA, TX_ESC2, TX_FCS_LO, TX_FCS_HI, TX_CLOSE
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_HUNT, RX_RECV, RX_FCS_A, RX_FCS_B, RX_STAT
    } rx_state_t;
endpackage

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t in_data,
    input  logic  in_valid,
    input  logic  in_last,
    output logic  in_ready,
    output byte_t out_data,
    output logic  out_valid,
    input  logic  out_ready
);
    tx_state_t   st, st_nx, ret_q, ret_nx, after_raw;
    byte_t       hold_q, hold_nx, raw;
    logic [15:0] crc_q, crc_nx;
    logic        fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            ret_q  <= TX_IDLE;
            hold_q <= '0;
            crc_q  <= CRC_INIT;
        end else begin
            st     <= st_nx;
            ret_q  <= ret_nx;
            hold_q <= hold_nx;
            crc_q  <= crc_nx;
        end
    end

    // byte to encode in the current state and where it leads
    always_comb begin
        raw       = in_data;
        after_raw = in_last ? TX_FCS_LO : TX_DATA;
        unique case (st)
            TX_FCS_LO: begin raw = ~crc_q[7:0];  after_raw = TX_FCS_HI; end
            TX_FCS_HI: begin raw = ~crc_q[15:8]; after_raw = TX_CLOSE;  end
            default: ;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = FLAG_B;
        in_ready  = 1'b0;
        unique case (st)
            TX_IDLE: ;
            TX_OPEN, TX_CLOSE: out_valid = 1'b1;
            TX_DATA: begin
                out_valid = in_valid;
                out_data  = needs_esc(raw) ? ESC_B : raw;
                in_ready  = out_ready;
            end
            TX_FCS_LO, TX_FCS_HI: begin
                out_valid = 1'b1;
                out_data  = needs_esc(raw) ? ESC_B : raw;
            end
            TX_ESC2: begin
                out_valid = 1'b1;
                out_data  = hold_q;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_nx   = st;
        ret_nx  = ret_q;
        hold_nx = hold_q;
        crc_nx  = crc_q;
        fire    = out_valid && out_ready;
        unique case (st)
            TX_IDLE:  if (in_valid) st_nx = TX_OPEN;
            TX_OPEN: begin
                crc_nx = CRC_INIT;
                if (fire) st_nx = TX_DATA;
            end
            TX_DATA, TX_FCS_LO, TX_FCS_HI: if (fire) begin
                if (st == TX_DATA) crc_nx = crc_step(crc_q, raw);
                if (needs_esc(raw)) begin
                    hold_nx = raw ^ FLIP_B;
                    ret_nx  = after_raw;
                    st_nx   = TX_ESC2;
                end else begin
                    st_nx = after_raw;
                end
            end
            TX_ESC2:  if (fire) st_nx = ret_q;
            TX_CLOSE: if (fire) st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    AST_TX_ESC_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data == ESC_B) |=>
        (out_valid && out_data != FLAG_B && out_data != ESC_B)); // R2

    AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) |-> (!out_valid && !in_ready)); // R1
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_pkg::*;
#(
    parameter byte_t BCAST_ADDR = 8'hFF,
    parameter int    MIN_BYTES  = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t in_data,
    input  logic  in_valid,
    output logic  in_ready,
    input  byte_t cfg_addr,
    input  logic  cfg_pass_fcs,
    output byte_t out_data,
    output logic  out_valid,
    output logic  out_eof,
    output logic  out_fcs_ok,
    output logic  out_abort,
    input  logic  out_ready
);
    localparam int CNT_W = $clog2(MIN_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);
    localparam logic [CNT_W-1:0] CNT_EMIT = CNT_W'(2);

    rx_state_t   st, st_nx;
    byte_t       d_old, d_new, dec, od_q;
    logic [CNT_W-1:0] cnt;
    logic        esc_q, drop_q, ov_q, oeof_q, ook_q, oab_q, sok_q, sab_q;
    logic [15:0] crc_q;
    logic        take, in_recv, end_frm, got_byte, bad, report;

    always_comb begin
        in_ready = (st == RX_HUNT) || (st == RX_RECV && !ov_q);
        take     = in_valid && in_ready;
        in_recv  = take && (st == RX_RECV);
        dec      = esc_q ? (in_data ^ FLIP_B) : in_data;
        end_frm  = in_recv && (in_data == FLAG_B);
        got_byte = in_recv && (in_data != FLAG_B) && (esc_q || in_data != ESC_B);
        bad      = esc_q || (cnt < CNT_MAX);
        report   = end_frm && !drop_q && (esc_q || cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_HUNT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_HUNT:  if (take && in_data == FLAG_B) st_nx = RX_RECV;
            RX_RECV:  if (report) st_nx = (bad || !cfg_pass_fcs) ? RX_STAT : RX_FCS_A;
            RX_FCS_A: if (!ov_q) st_nx = RX_FCS_B;
            RX_FCS_B: if (!ov_q) st_nx = RX_STAT;
            RX_STAT:  if (!ov_q) st_nx = RX_RECV;
            default:  st_nx = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_old <= '0;  d_new <= '0;  cnt <= '0;
            esc_q <= 1'b0; drop_q <= 1'b0; crc_q <= CRC_INIT;
            sok_q <= 1'b0; sab_q <= 1'b0;
            ov_q <= 1'b0; od_q <= '0; oeof_q <= 1'b0; ook_q <= 1'b0; oab_q <= 1'b0;
        end else begin
            if (ov_q && out_ready) ov_q <= 1'b0;
            if (end_frm) begin
                sok_q  <= !bad && (crc_q == CRC_GOOD);
                sab_q  <= bad;
                cnt    <= '0;
                esc_q  <= 1'b0;
                drop_q <= 1'b0;
                crc_q  <= CRC_INIT;
            end else if (in_recv && !esc_q && in_data == ESC_B) begin
                esc_q <= 1'b1;
            end else if (got_byte) begin
                esc_q <= 1'b0;
                if (cnt == '0 && dec != cfg_addr && dec != BCAST_ADDR) drop_q <= 1'b1;
                if (cnt >= CNT_EMIT && !drop_q) begin
                    ov_q <= 1'b1; od_q <= d_old;
                    oeof_q <= 1'b0; ook_q <= 1'b0; oab_q <= 1'b0;
                end
                d_old <= d_new;
                d_new <= dec;
                crc_q <= crc_step(crc_q, dec);
                if (cnt < CNT_MAX) cnt <= cnt + 1'b1;
            end
            if (!ov_q) begin
                unique case (st)
                    RX_FCS_A: begin ov_q <= 1'b1; od_q <= d_old; oeof_q <= 1'b0;
                                    ook_q <= 1'b0; oab_q <= 1'b0; end
                    RX_FCS_B: begin ov_q <= 1'b1; od_q <= d_new; oeof_q <= 1'b0;
                                    ook_q <= 1'b0; oab_q <= 1'b0; end
                    RX_STAT:  begin ov_q <= 1'b1; od_q <= '0; oeof_q <= 1'b1;
                                    ook_q <= sok_q; oab_q <= sab_q; end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        out_valid  = ov_q;
        out_data   = od_q;
        out_eof    = oeof_q;
        out_fcs_ok = ook_q;
        out_abort  = oab_q;
    end

    AST_RX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_eof))); // R9

    AST_RX_ABORT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_abort) |-> (out_eof && !out_fcs_ok)); // R8

    AST_RX_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_HUNT) |=> !$rose(out_valid)); // R4
endmodule

// File: rtl/hdlc_async_codec.sv
module hdlc_async_codec
    import hdlc_pkg::*;
#(
    parameter logic [7:0] BCAST_ADDR = 8'hFF,
    parameter int         MIN_BYTES  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       tx_last,
    output logic       tx_ready,
    output logic [7:0] line_tx_data,
    output logic       line_tx_valid,
    input  logic       line_tx_ready,
    input  logic [7:0] line_rx_data,
    input  logic       line_rx_valid,
    output logic       line_rx_ready,
    input  logic [7:0] cfg_addr,
    input  logic       cfg_pass_fcs,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_eof,
    output logic       rx_fcs_ok,
    output logic       rx_abort,
    input  logic       rx_ready
);
    hdlc_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_data(tx_data), .in_valid(tx_valid), .in_last(tx_last), .in_ready(tx_ready),
        .out_data(line_tx_data), .out_valid(line_tx_valid), .out_ready(line_tx_ready)
    );

    hdlc_rx #(.BCAST_ADDR(BCAST_ADDR), .MIN_BYTES(MIN_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_data(line_rx_data), .in_valid(line_rx_valid), .in_ready(line_rx_ready),
        .cfg_addr(cfg_addr), .cfg_pass_fcs(cfg_pass_fcs),
        .out_data(rx_data), .out_valid(rx_valid), .out_eof(rx_eof),
        .out_fcs_ok(rx_fcs_ok), .out_abort(rx_abort), .out_ready(rx_ready)
    );
endmodule

// File: tb/sim_hdlc_async_codec.sv
`timescale 1ns/1ps
module sim_hdlc_async_codec;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic [7:0] tx_data, line_tx_data, line_rx_data, cfg_addr, rx_data;
    logic tx_valid, tx_last, tx_ready, line_tx_valid, line_tx_ready;
    logic line_rx_valid, line_rx_ready, cfg_pass_fcs;
    logic rx_valid, rx_eof, rx_fcs_ok, rx_abort, rx_ready;

    hdlc_async_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .line_tx_data(line_tx_data), .line_tx_valid(line_tx_valid), .line_tx_ready(line_tx_ready),
        .line_rx_data(line_rx_data), .line_rx_valid(line_rx_valid), .line_rx_ready(line_rx_ready),
        .cfg_addr(cfg_addr), .cfg_pass_fcs(cfg_pass_fcs),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_eof(rx_eof),
        .rx_fcs_ok(rx_fcs_ok), .rx_abort(rx_abort), .rx_ready(rx_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [10:0] txq[$];
    logic [10:0] rxq[$];

    typedef struct packed {
        logic [3:0]  len;
        logic [7:0]  addr;
        logic        pass;
        logic        drop;
        logic        bp;
        logic [47:0] pl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{4'd4, 8'h12, 1'b0, 1'b0, 1'b0, 48'h1203_4142_0000},
        '{4'd4, 8'h12, 1'b1, 1'b0, 1'b1, 48'h127E_7D55_0000},
        '{4'd2, 8'h12, 1'b0, 1'b1, 1'b0, 48'h3401_0000_0000},
        '{4'd2, 8'h12, 1'b0, 1'b0, 1'b1, 48'hFF09_0000_0000},
        '{4'd1, 8'h12, 1'b1, 1'b0, 1'b0, 48'h1200_0000_0000},
        '{4'd6, 8'h5A, 1'b0, 1'b0, 1'b1, 48'h5A7D_7D7E_00FF}
    };

    function automatic logic [15:0] fcs_of(input logic [7:0] q[$]);
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (q[i]) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ q[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic encode(input logic [7:0] fr[$], output logic [7:0] ln[$]);
        logic [7:0] body[$];
        logic [15:0] c;
        body = fr;
        c = ~fcs_of(fr);
        body.push_back(c[7:0]);
        body.push_back(c[15:8]);
        ln.delete();
        ln.push_back(8'h7E);
        foreach (body[i]) begin
            if (body[i] == 8'h7E || body[i] == 8'h7D) begin
                ln.push_back(8'h7D);
                ln.push_back(body[i] ^ 8'h20);
            end else ln.push_back(body[i]);
        end
        ln.push_back(8'h7E);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmp_q(input logic [10:0] got[$], input logic [10:0] exp[$],
                         input string req, input string what);
        int n;
        int bad_i;
        n = (got.size() > exp.size()) ? got.size() : exp.size();
        bad_i = -1;
        for (int i = 0; i < n; i++) begin
            logic [10:0] g;
            logic [10:0] e;
            g = (i < got.size()) ? got[i] : 11'h7FF;
            e = (i < exp.size()) ? exp[i] : 11'h7FF;
            if (bad_i < 0 && g !== e) bad_i = i;
        end
        n_chk++;
        if (bad_i >= 0) begin
            n_bad++;
            $display("FAIL %s %s: item %0d actual %h expected %h (count %0d vs %0d)", req, what,
                     bad_i, (bad_i < got.size()) ? got[bad_i] : 11'h7FF,
                     (bad_i < exp.size()) ? exp[bad_i] : 11'h7FF, got.size(), exp.size());
        end
    endtask

    task automatic run_tx(input logic [7:0] fr[$], input bit bp);
        int i;
        int guard;
        bit ph;
        i = 0; guard = 0; ph = 1'b0;
        txq.delete();
        while (guard < 400 && !(i == fr.size() && txq.size() > 1 && txq[$] == 11'h07E)) begin
            @(negedge clk);
            guard++;
            ph = ~ph;
            line_tx_ready = bp ? ph : 1'b1;
            tx_valid = (i < fr.size());
            tx_data  = (i < fr.size()) ? fr[i] : 8'h00;
            tx_last  = (i == fr.size() - 1);
            #1;
            if (line_tx_valid && line_tx_ready) txq.push_back({3'b000, line_tx_data});
            if (tx_valid && tx_ready) i++;
        end
        @(negedge clk);
        tx_valid = 1'b0; tx_last = 1'b0; line_tx_ready = 1'b1;
    endtask

    task automatic run_rx(input logic [7:0] ln[$], input bit bp);
        int i;
        int quiet;
        bit ph;
        i = 0; quiet = 0; ph = 1'b0;
        rxq.delete();
        while (quiet < 24) begin
            @(negedge clk);
            ph = ~ph;
            rx_ready = bp ? ph : 1'b1;
            line_rx_valid = (i < ln.size());
            line_rx_data  = (i < ln.size()) ? ln[i] : 8'h00;
            #1;
            if (rx_valid && rx_ready) rxq.push_back({rx_abort, rx_fcs_ok, rx_eof, rx_data});
            if (line_rx_valid && line_rx_ready) i++;
            if (i >= ln.size()) quiet++;
        end
        line_rx_valid = 1'b0; rx_ready = 1'b1;
    endtask

    task automatic data_beats(input logic [7:0] q[$], inout logic [10:0] b[$]);
        foreach (q[i]) b.push_back({3'b000, q[i]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] fr[$];
        logic [7:0] ln[$];
        logic [7:0] ln2[$];
        logic [10:0] eb[$];
        logic [15:0] fc;
        rst_n = 1'b0;
        tx_data = 8'h00; tx_valid = 1'b0; tx_last = 1'b0; line_tx_ready = 1'b1;
        line_rx_data = 8'h00; line_rx_valid = 1'b0; rx_ready = 1'b1;
        cfg_addr = 8'h12; cfg_pass_fcs = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 R4: reset state
        chk(!line_tx_valid && !tx_ready, "R1", "tx idle after reset",
            {30'd0, line_tx_valid, tx_ready}, 32'd0);
        chk(!rx_valid && line_rx_ready, "R4", "rx hunting after reset",
            {30'd0, rx_valid, line_rx_ready}, 32'd1);

        // R4: garbage before the first flag plus empty frames, then a good frame
        fr = '{8'h12, 8'h77, 8'h88};
        encode(fr, ln);
        ln2 = '{8'h55, 8'h12, 8'h34, 8'h7E, 8'h7E, 8'h7E};
        foreach (ln[i]) ln2.push_back(ln[i]);
        run_rx(ln2, 1'b0);
        eb.delete(); data_beats(fr, eb); eb.push_back(11'h300);
        cmp_q(rxq, eb, "R4", "hunt and empty frames");

        // table of frames: tx encoding, then loop the line bytes into rx
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            e = VEC[v];
            fr.delete();
            for (int k = 0; k < int'(e.len); k++) fr.push_back(e.pl[47 - 8*k -: 8]);
            cfg_addr = e.addr; cfg_pass_fcs = e.pass;
            run_tx(fr, e.bp);
            encode(fr, ln);
            eb.delete(); data_beats(ln, eb);
            cmp_q(txq, eb, "R3", $sformatf("tx line vector %0d (R1 R2 R9)", v));
            ln2.delete();
            foreach (txq[i]) ln2.push_back(txq[i][7:0]);
            run_rx(ln2, e.bp);
            eb.delete();
            if (!e.drop) begin
                data_beats(fr, eb);
                if (e.pass) begin
                    fc = ~fcs_of(fr);
                    eb.push_back({3'b000, fc[7:0]});
                    eb.push_back({3'b000, fc[15:8]});
                end
                eb.push_back(11'h300);
            end
            cmp_q(rxq, eb, e.drop ? "R5" : (e.pass ? "R7" : "R6"),
                  $sformatf("rx beats vector %0d", v));
        end
        cfg_addr = 8'h12; cfg_pass_fcs = 1'b0;

        // R6: corrupted FCS
        fr = '{8'h12, 8'h03, 8'hAA, 8'hBB};
        ln2 = '{8'h7E, 8'h12, 8'h03, 8'hAA, 8'hBB, 8'h7E};
        run_rx(ln2, 1'b0);
        eb.delete();
        eb.push_back(11'h012); eb.push_back(11'h003);
        eb.push_back((fcs_of(fr) == 16'hF0B8) ? 11'h300 : 11'h100);
        cmp_q(rxq, eb, "R6", "bad fcs status");

        // R8: runt of two bytes
        ln2 = '{8'h7E, 8'h12, 8'h05, 8'h7E};
        run_rx(ln2, 1'b0);
        eb = '{11'h500};
        cmp_q(rxq, eb, "R8", "runt frame");

        // R8: escape directly before flag
        ln2 = '{8'h7E, 8'h12, 8'h03, 8'h04, 8'h05, 8'h7D, 8'h7E};
        run_rx(ln2, 1'b0);
        eb = '{11'h012, 11'h003, 11'h500};
        cmp_q(rxq, eb, "R8", "escape then flag");

        // R5: recovery after abort, address accepted again
        fr = '{8'h12, 8'h7D};
        encode(fr, ln);
        run_rx(ln, 1'b0);
        eb.delete(); data_beats(fr, eb); eb.push_back(11'h300);
        cmp_q(rxq, eb, "R5", "frame after abort");

        // R10: both directions at once
        fr = '{8'h12, 8'h7E, 8'h01};
        encode(fr, ln);
        ln2 = '{8'h12, 8'h44, 8'h7D, 8'h99};
        fork
            run_tx(ln2, 1'b1);
            run_rx(ln, 1'b1);
        join
        eb.delete(); data_beats(fr, eb); eb.push_back(11'h300);
        cmp_q(rxq, eb, "R10", "rx during tx");
        encode(ln2, ln);
        eb.delete(); data_beats(ln, eb);
        cmp_q(txq, eb, "R10", "tx during rx");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule